// File: doc/BRIEF.md
# SRAM Address/Data Line Test Sequencer

This block is a synchronous controller that checks the wiring between a chip and an external asynchronous static RAM. It owns the RAM's active-low chip enable, output enable and write enable, its address bus, and the output half of a split data bus (value plus drive enable), and it samples the returned data. One start pulse runs three tests back to back. The first is a walking-address write and read-back pass that exposes stuck or shorted address and data lines. The second is an output-enable float check and the third a chip-enable float check. Both rely on board pull-ups, so a released bus reads as all ones.

Every bus step has four phases, and each phase lasts `HOLD` clock cycles so that the RAM's access times are met. The sequencer stops at the first read that returns a wrong value. It then raises `done` and reports which test and which step within that test failed. If all three tests finish cleanly, it raises `done` with `pass` set. The controls and the verdict are plain level signals, because the block has no data stream at its edge.

Top module: `sram_line_tester`

## Requirements
- R1: Test index 0 writes to the address list 0x0000, 0x0001, 0x0002, 0x0004, ..., 0x2000 (zero, then each single-bit address from bit 0 up to bit ADDR_W-1) at steps 0 to 14. At step k it writes the value k. Every address driven during test 0 has at most one bit set.
- R2: Test index 0 finishes all 15 writes before its first read. Steps 15 to 29 read the same addresses in the same order, and each read expects the value written at that address.
- R3: A write step drives the address alone in phase 0. It pulls `we_n` low in phase 1, drives the data (`dq_oe`=1) with `we_n` still low in phase 2, and in phase 3 raises `we_n` and releases the data. `dq_oe` is never 1 while `we_n` is high, and the address is held stable while `we_n` is low.
- R4: A read step keeps `we_n` high and `dq_oe` low for all four phases. Phase 2 is not checked. `dq_in` is compared only in the last cycle of phase 3.
- R5: Each phase lasts exactly HOLD cycles, so a full passing run takes 38 steps × 4 × HOLD cycles from the clock edge that accepts `start` to the edge that raises `done`.
- R6: Test index 1 runs four steps: write 0x0 to address 0, read back 0x0, read with `oe_n` high expecting 0xF, then read 0x0 again.
- R7: Test index 2 follows the same four steps as test 1, except that step 2 raises `ce_n` instead and `oe_n` stays low.
- R8: While a test runs, `ce_n` and `oe_n` are low in every step except the single float read of R6/R7. While idle or done, `ce_n`, `oe_n` and `we_n` are high, `dq_oe` is low and the address is 0.
- R9: `start` is accepted while idle or done and restarts from test 0, step 0. While the sequence runs, `start` is ignored.
- R10: The first mismatching read ends the run. `done`=1, `pass`=0, and `fail_test`/`fail_step` give that read's test and step. A clean run ends with `done`=1, `pass`=1 and both indices 0. The verdict holds until the next `start`.
- R11: After reset, `done`, `busy` and `pass` are 0 and the bus is in the idle state of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test run |
| dq_in | input | DATA_W | Data sampled from the RAM bus |
| ce_n | output | 1 | RAM chip enable, active low |
| oe_n | output | 1 | RAM output enable, active low |
| we_n | output | 1 | RAM write enable, active low |
| addr | output | ADDR_W | RAM address |
| dq_out | output | DATA_W | Data to drive onto the RAM bus |
| dq_oe | output | 1 | Drive enable for dq_out |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished, verdict valid |
| pass | output | 1 | All tests passed (valid with done) |
| fail_test | output | 2 | Test index of the first mismatch |
| fail_step | output | STEP_W | Step index of the first mismatch |

## Verification
The sharpest collision is a mismatch on the very last read of the last test. In that cycle the compare and the end-of-sequence decision fall together, and the fault must win, giving fail on test 2, step 3, and never a pass. The bench provokes this with a RAM model that corrupts address 0 whenever chip enable is released. The second collision is a `start` pulse in the middle of a run. It is judged by the run still ending at the exact R5 cycle count with a clean verdict.

// File: rtl/sram_tst_pkg.sv
package sram_tst_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} ctl_state_t;
  typedef enum logic [1:0] {PH_ADDR, PH_STROBE, PH_DATA, PH_FINISH} phase_t;
  localparam logic [1:0] TEST_WALK = 2'd0;
  localparam logic [1:0] TEST_OE   = 2'd1;
  localparam logic [1:0] TEST_CE   = 2'd2;
endpackage

// File: rtl/sram_tst_phase_timer.sv
module sram_tst_phase_timer #(
  parameter int HOLD = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic phase_end
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run)         cnt <= '0;
    else if (cnt == LAST)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign phase_end = run && (cnt == LAST);

  // R5: the dwell counter never passes its hold limit
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/sram_tst_step_rom.sv
module sram_tst_step_rom
  import sram_tst_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 4,
  parameter int STEP_W = 5
) (
  input  logic [1:0]        test_i,
  input  logic [STEP_W-1:0] step_i,
  output logic              is_write,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic              ce_hi,
  output logic              oe_hi,
  output logic              last
);
  localparam int WALK_N = ADDR_W + 1;
  localparam logic [STEP_W-1:0] WALK_NS = STEP_W'(WALK_N);
  localparam logic [STEP_W-1:0] WALK_LAST = STEP_W'(2 * WALK_N - 1);
  localparam logic [STEP_W-1:0] FLOAT_STEP = STEP_W'(2);
  localparam logic [STEP_W-1:0] FLOAT_LAST = STEP_W'(3);

  logic [ADDR_W-1:0] walk_tab [WALK_N];

  for (genvar k = 0; k < WALK_N; k++) begin : g_walk
    if (k == 0) begin : g_zero
      assign walk_tab[k] = '0;
    end else begin : g_bit
      assign walk_tab[k] = ADDR_W'(1) << (k - 1);
    end
  end

  logic [STEP_W-1:0] k_idx;
  assign k_idx = (step_i < WALK_NS) ? step_i : step_i - WALK_NS;

  always_comb begin
    is_write = 1'b0;
    op_addr  = '0;
    op_data  = '0;
    ce_hi    = 1'b0;
    oe_hi    = 1'b0;
    last     = 1'b0;
    if (test_i == TEST_WALK) begin
      is_write = step_i < WALK_NS;
      op_addr  = walk_tab[k_idx];
      op_data  = DATA_W'(k_idx);
      last     = step_i == WALK_LAST;
    end else begin
      is_write = step_i == '0;
      op_data  = (step_i == FLOAT_STEP) ? '1 : '0;
      ce_hi    = (test_i == TEST_CE) && (step_i == FLOAT_STEP);
      oe_hi    = (test_i == TEST_OE) && (step_i == FLOAT_STEP);
      last     = step_i == FLOAT_LAST;
    end
  end
endmodule

// File: rtl/sram_line_tester.sv
module sram_line_tester
  import sram_tst_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 4,
  parameter int HOLD   = 1,
  localparam int STEP_W = $clog2(2 * ADDR_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] dq_in,
  output logic              ce_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [1:0]        fail_test,
  output logic [STEP_W-1:0] fail_step
);
  ctl_state_t        state;
  phase_t            phase;
  logic [1:0]        test_q;
  logic [STEP_W-1:0] step_q;
  logic              pass_q;
  logic [1:0]        ftest_q;
  logic [STEP_W-1:0] fstep_q;
  logic              phase_end;

  logic              op_write, op_ce_hi, op_oe_hi, op_last;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_data;

  sram_tst_phase_timer #(.HOLD(HOLD)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state == ST_RUN), .phase_end(phase_end)
  );

  sram_tst_step_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP_W(STEP_W)) u_rom (
    .test_i(test_q), .step_i(step_q), .is_write(op_write), .op_addr(op_addr),
    .op_data(op_data), .ce_hi(op_ce_hi), .oe_hi(op_oe_hi), .last(op_last)
  );

  always_comb begin
    ce_n   = 1'b1;
    oe_n   = 1'b1;
    we_n   = 1'b1;
    addr   = '0;
    dq_out = '0;
    dq_oe  = 1'b0;
    if (state == ST_RUN) begin
      ce_n = op_ce_hi;
      oe_n = op_oe_hi;
      addr = op_addr;
      if (op_write) begin
        we_n   = !((phase == PH_STROBE) || (phase == PH_DATA));
        dq_oe  = phase == PH_DATA;
        dq_out = op_data;
      end
    end
  end

  logic rd_bad;
  assign rd_bad = !op_write && (dq_in != op_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      phase   <= PH_ADDR;
      test_q  <= '0;
      step_q  <= '0;
      pass_q  <= 1'b0;
      ftest_q <= '0;
      fstep_q <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            state   <= ST_RUN;
            phase   <= PH_ADDR;
            test_q  <= TEST_WALK;
            step_q  <= '0;
            pass_q  <= 1'b0;
            ftest_q <= '0;
            fstep_q <= '0;
          end
        end
        ST_RUN: begin
          if (phase_end) begin
            if (phase != PH_FINISH) begin
              phase <= phase_t'(phase + 2'd1);
            end else begin
              phase <= PH_ADDR;
              if (rd_bad) begin
                state   <= ST_DONE;
                ftest_q <= test_q;
                fstep_q <= step_q;
              end else if (op_last) begin
                step_q <= '0;
                if (test_q == TEST_CE) begin
                  state  <= ST_DONE;
                  pass_q <= 1'b1;
                end else begin
                  test_q <= test_q + 2'd1;
                end
              end else begin
                step_q <= step_q + 1'b1;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = state == ST_RUN;
  assign done      = state == ST_DONE;
  assign pass      = pass_q;
  assign fail_test = ftest_q;
  assign fail_step = fstep_q;

  // R3: data is driven only under an active write strobe
  p_drive_in_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !we_n);
  // R3: address held while the strobe is low
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> $stable(addr));
  // R4: the bus is released as soon as the strobe rises
  p_release_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> !dq_oe);
  // R8: writes happen with both enables asserted
  p_enables_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ce_n && !oe_n));
  // R1: walking addresses carry at most one set bit
  p_walk_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && test_q == TEST_WALK) |-> ($countones(addr) <= 1));
  // R10: the bus is quiet once the verdict is out
  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (we_n && ce_n && oe_n && !dq_oe));
  // R10: the verdict holds until a new start
  p_verdict_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(pass) && $stable(fail_test) && $stable(fail_step)));
endmodule

// File: tb/test_sram_line_tester.sv
module test_sram_line_tester;
  localparam int ADDR_W = 14;
  localparam int DATA_W = 4;
  localparam int HOLD   = 2;
  localparam int STEP_W = 5;
  localparam int STEP_CYC = 4 * HOLD;
  localparam int RUN_CYC  = 38 * STEP_CYC;
  localparam int LIMIT    = 4000;

  typedef struct packed {
    logic [3:0] fault;
    logic       exp_pass;
    logic [1:0] exp_test;
    logic [4:0] exp_step;
  } vec_t;

  // fault: 0 none, 1 addr bits 12/13 shorted, 2 addr bit 0 stuck high,
  // 3 no pull-up, 4 RAM ignores oe_n, 5 RAM ignores ce_n,
  // 6 data bit 3 reads low, 7 address 0 corrupted when ce_n rises
  localparam vec_t VECS [8] = '{
    '{4'd0, 1'b1, 2'd0, 5'd0},
    '{4'd1, 1'b0, 2'd0, 5'd28},
    '{4'd2, 1'b0, 2'd0, 5'd15},
    '{4'd3, 1'b0, 2'd1, 5'd2},
    '{4'd4, 1'b0, 2'd1, 5'd2},
    '{4'd5, 1'b0, 2'd2, 5'd2},
    '{4'd6, 1'b0, 2'd0, 5'd23},
    '{4'd7, 1'b0, 2'd2, 5'd3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [DATA_W-1:0] dq_in = '1;
  logic ce_n, oe_n, we_n, dq_oe, busy, done, pass;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] dq_out;
  logic [1:0] fail_test;
  logic [STEP_W-1:0] fail_step;

  int n_checks = 0;
  int n_fail = 0;
  int fault = 0;
  logic prev_ce_n = 1'b1;
  logic [DATA_W-1:0] mem [int];

  always #2 clk = ~clk;

  sram_line_tester #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HOLD(HOLD)) i_sram_line_tester (
    .clk(clk), .rst_n(rst_n), .start(start), .dq_in(dq_in),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr), .dq_out(dq_out),
    .dq_oe(dq_oe), .busy(busy), .done(done), .pass(pass),
    .fail_test(fail_test), .fail_step(fail_step)
  );

  // RAM and pull-up model, updated away from the active edge
  always @(negedge clk) begin
    int ea;
    logic drv;
    logic [DATA_W-1:0] v;
    ea = int'(addr);
    if (fault == 1 && (addr[12] || addr[13])) ea = ea | 32'h3000;
    if (fault == 2) ea = ea | 1;
    if (!ce_n && !we_n && dq_oe) mem[ea] = dq_out;
    if (fault == 7 && ce_n && !prev_ce_n) mem[0] = 4'h5;
    prev_ce_n = ce_n;
    case (fault)
      4: drv = !ce_n && we_n;
      5: drv = !oe_n && we_n;
      default: drv = !ce_n && !oe_n && we_n;
    endcase
    if (drv) begin
      v = mem.exists(ea) ? mem[ea] : 4'hA;
      if (fault == 6) v[3] = 1'b0;
    end else begin
      v = (fault == 3) ? 4'h0 : 4'hF;
    end
    dq_in = v;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic probe(input int n);
    case (n)
      1: begin chk("R8 enables low in run", {ce_n, oe_n}, 0);
               chk("R5 phase 0 still held", we_n, 1); end
      2: begin chk("R3 strobe low", we_n, 0); chk("R3 no drive in strobe phase", dq_oe, 0); end
      4: begin chk("R3 data driven", dq_oe, 1); chk("R3 strobe still low", we_n, 0);
               chk("R1 value 0 at step 0", dq_out, 0); end
      6: begin chk("R3 strobe raised", we_n, 1); chk("R3 data released", dq_oe, 0); end
      16: chk("R1 step 2 address", addr, 32'h0002);
      104: chk("R1 step 13 address", addr, 32'h1000);
      108: chk("R1 step 13 data", {dq_oe, dq_out}, 32'h1D);
      112: chk("R1 step 14 address", addr, 32'h2000);
      120: chk("R2 first read at address 0", {we_n, addr}, 32'h4000);
      124: chk("R4 read keeps bus released", {we_n, dq_oe}, 32'h2);
      128: chk("R2 second read address", addr, 32'h0001);
      256: chk("R6 float read oe high ce low", {ce_n, oe_n}, 32'h1);
      288: chk("R7 float read ce high oe low", {ce_n, oe_n}, 32'h2);
      default: ;
    endcase
  endtask

  task automatic run(input bit do_probe, input int restart_at, output int n);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    n = 0;
    while (!done && n < LIMIT) begin
      @(negedge clk);
      n++;
      if (n == restart_at) start = 1'b1;
      if (n == restart_at + 1) start = 1'b0;
      if (do_probe) probe(n);
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual no done expected done within %0d", LIMIT);
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 done", done, 0);
    chk("R11 busy", busy, 0);
    chk("R11 pass", pass, 0);
    chk("R11 idle strobes", {ce_n, oe_n, we_n, dq_oe}, 32'hE);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 idle address", addr, 0);

    for (int i = 0; i < 8; i++) begin
      fault = int'(VECS[i].fault);
      run(i == 0, -10, n);
      chk("R10 pass flag", pass, VECS[i].exp_pass);
      chk("R10 fail test", fail_test, VECS[i].exp_test);
      chk("R10 fail step", fail_step, VECS[i].exp_step);
      if (i == 0) chk("R5 run length", n, RUN_CYC);
    end

    // R10 verdict holds after the final fault scenario
    repeat (4) @(negedge clk);
    chk("R10 verdict held", {done, pass, fail_test, fail_step}, {1'b1, 1'b0, 2'd2, 5'd3});
    chk("R8 bus idle while done", {ce_n, oe_n, we_n, dq_oe}, 32'hE);

    // R9 start mid-run is ignored; done restarts
    fault = 0;
    run(1'b0, 50, n);
    chk("R9 mid-run start ignored", n, RUN_CYC);
    chk("R9 clean verdict after restart", {done, pass}, 32'h3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule